// File: doc/BRIEF.md
# Tiled matrix multiply controller

This block computes the product of two square matrices of size N x N, where N is chosen per run from 2, 4, 8 and 16. Only one 4x4 multiply core is used for every size. The controller cuts both operands into 4x4 tiles and runs the core once for each tile pair that feeds an output tile. It adds the partial tile products together and then writes each finished element to a result memory.

The operands sit in two 32-bit input memories. Each has a read port with one cycle of latency and is addressed as row*N+col. Results are 64-bit and go through a write port into a separate output memory, using the same addressing. The 4x4 core sits outside the block and is reached through a launch/complete handshake. A run begins with a start pulse that carries a size code. It ends with a one-cycle done pulse.

Top module: `mm_tile_ctrl`

## Requirements
- R1: On `start_i` while idle, `size_i` selects N: code 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. For every row and column below N, the element C = A x B (unsigned, modulo 2^64) is written to output address row*N+col.
- R2: Operand element (row, col) is read from address row*N+col of its input memory. `a_data_i` and `b_data_i` are taken one cycle after the address is presented with the read strobe high.
- R3: `core_start_o` is high for exactly one cycle per core launch. At that cycle, `core_a_o` holds tile A(I,k) and `core_b_o` holds tile B(k,J). Tile entry (r,c) lies in bits [(r*4+c)*32 +: 32]. Launches run in the order I, then J, then k, with k innermost.
- R4: For each output tile, the result is the sum over k from 0 to N/4-1 (one term when N=2) of the core outputs. The running sum starts afresh at every new output tile.
- R5: When N=2, every operand tile entry with r>=2 or c>=2 is zero at launch.
- R6: Each element of the N x N result is written exactly once. No write goes outside the first N*N addresses, and writes arrive in row-major order of output tiles.
- R7: `done_o` is high for one cycle, in the cycle right after the last result write.
- R8: `start_i` has no effect while a run is in progress.
- R9: After reset, `done_o`, `wr_en_o` and `core_start_o` are low.
- R10: A new core launch never begins while an earlier one has not yet returned `core_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (sampled while idle) |
| size_i | input | 2 | Size code: N = 2 << size_i |
| done_o | output | 1 | One-cycle end-of-run pulse |
| a_rd_o | output | 1 | Read strobe, A memory |
| a_addr_o | output | 8 | Read address, A memory |
| a_data_i | input | 32 | Read data, A memory (1-cycle latency) |
| b_rd_o | output | 1 | Read strobe, B memory |
| b_addr_o | output | 8 | Read address, B memory |
| b_data_i | input | 32 | Read data, B memory (1-cycle latency) |
| wr_en_o | output | 1 | Result write enable |
| wr_addr_o | output | 8 | Result write address |
| wr_data_o | output | 64 | Result write data |
| core_start_o | output | 1 | Launch pulse to the 4x4 core |
| core_a_o | output | 512 | Left operand tile, 16 entries of 32 bits |
| core_b_o | output | 512 | Right operand tile, 16 entries of 32 bits |
| core_done_i | input | 1 | Core result valid pulse |
| core_c_i | input | 1024 | Core result tile, 16 entries of 64 bits |

## Verification
Two situations are hard to reach from the ports. The first is a tile boundary, where a partial sum has to be dropped rather than carried into the next output tile. The second is the N=2 case, where stale operand entries from an earlier larger run could leak into the padding. The bench runs every size back to back, so a 2x2 run follows runs of 16x16 and 8x8 data. It uses all-ones operands so that the modulo-2^64 sums wrap. Every core launch is compared against the tile the bench expects from the launch count. A second start with a different size code is injected in the middle of an 8x8 run.

// File: rtl/mm_tile_pkg.sv
package mm_tile_pkg;
  localparam int TILE     = 4;
  localparam int TILE_ENT = TILE * TILE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LAST,
    ST_FIRE,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } mm_state_e;
endpackage

// File: rtl/mm_tile_addr.sv
module mm_tile_addr #(
  parameter int MAX_LG = 4,
  localparam int BW = MAX_LG - 2,
  localparam int AW = 2 * MAX_LG
) (
  input  logic [2:0]    lg_i,
  input  logic [BW-1:0] blk_r_i,
  input  logic [BW-1:0] blk_c_i,
  input  logic [1:0]    r_i,
  input  logic [1:0]    c_i,
  output logic [AW-1:0] addr_o
);
  logic [MAX_LG-1:0] row, col;

  assign row    = {blk_r_i, r_i};
  assign col    = {blk_c_i, c_i};
  assign addr_o = (AW'(row) << lg_i) | AW'(col);
endmodule

// File: rtl/mm_tile_opnd.sv
module mm_tile_opnd
  import mm_tile_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   we_i,
  input  logic [3:0]             idx_i,
  input  logic [DW-1:0]          a_i,
  input  logic [DW-1:0]          b_i,
  output logic [TILE_ENT*DW-1:0] a_o,
  output logic [TILE_ENT*DW-1:0] b_o
);
  for (genvar e = 0; e < TILE_ENT; e++) begin : g_ent
    logic [DW-1:0] a_q, b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        b_q <= '0;
      end else if (clr_i) begin
        a_q <= '0;
        b_q <= '0;
      end else if (we_i && idx_i == 4'(e)) begin
        a_q <= a_i;
        b_q <= b_i;
      end
    end
    assign a_o[e*DW +: DW] = a_q;
    assign b_o[e*DW +: DW] = b_q;
  end
endmodule

// File: rtl/mm_tile_psum.sv
module mm_tile_psum
  import mm_tile_pkg::*;
#(
  parameter int OW = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   clr_i,
  input  logic [TILE_ENT*OW-1:0] c_i,
  input  logic [3:0]             rd_idx_i,
  output logic [OW-1:0]          rd_o
);
  logic [OW-1:0] sum_q [TILE_ENT];

  for (genvar e = 0; e < TILE_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sum_q[e] <= '0;
      else if (en_i)  sum_q[e] <= clr_i ? c_i[e*OW +: OW] : sum_q[e] + c_i[e*OW +: OW];
    end
  end

  assign rd_o = sum_q[rd_idx_i];
endmodule

// File: rtl/mm_tile_ctrl.sv
module mm_tile_ctrl
  import mm_tile_pkg::*;
#(
  parameter int DW     = 32,
  parameter int OW     = 64,
  parameter int MAX_LG = 4,
  localparam int BW = MAX_LG - 2,
  localparam int AW = 2 * MAX_LG
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             size_i,
  output logic                   done_o,
  output logic                   a_rd_o,
  output logic [AW-1:0]          a_addr_o,
  input  logic [DW-1:0]          a_data_i,
  output logic                   b_rd_o,
  output logic [AW-1:0]          b_addr_o,
  input  logic [DW-1:0]          b_data_i,
  output logic                   wr_en_o,
  output logic [AW-1:0]          wr_addr_o,
  output logic [OW-1:0]          wr_data_o,
  output logic                   core_start_o,
  output logic [TILE_ENT*DW-1:0] core_a_o,
  output logic [TILE_ENT*DW-1:0] core_b_o,
  input  logic                   core_done_i,
  input  logic [TILE_ENT*OW-1:0] core_c_i
);
  mm_state_e     st_q;
  logic [2:0]    lg_q;
  logic [1:0]    lim_q;
  logic [BW-1:0] nbm1_q, bi_q, bj_q, kk_q;
  logic [1:0]    r_q, c_q;
  logic          cap_v_q;
  logic [3:0]    cap_idx_q;
  logic [BW-1:0] nbm1_d;
  logic          pos_last, accum, opnd_clr;

  always_comb begin
    if (size_i < 2'd2) nbm1_d = '0;
    else               nbm1_d = BW'((1 << (size_i - 2'd1)) - 1);
  end

  assign pos_last = (r_q == lim_q) && (c_q == lim_q);
  assign accum    = (st_q == ST_WAIT) && core_done_i;
  assign opnd_clr = (st_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      lg_q      <= 3'd1;
      lim_q     <= 2'd3;
      nbm1_q    <= '0;
      bi_q      <= '0;
      bj_q      <= '0;
      kk_q      <= '0;
      r_q       <= '0;
      c_q       <= '0;
      cap_v_q   <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_v_q   <= (st_q == ST_LOAD);
      cap_idx_q <= {r_q, c_q};
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          lg_q   <= {1'b0, size_i} + 3'd1;
          lim_q  <= (size_i == 2'd0) ? 2'd1 : 2'd3;
          nbm1_q <= nbm1_d;
          bi_q   <= '0;
          bj_q   <= '0;
          kk_q   <= '0;
          r_q    <= '0;
          c_q    <= '0;
          st_q   <= ST_LOAD;
        end
        ST_LOAD: begin
          if (pos_last) begin
            r_q  <= '0;
            c_q  <= '0;
            st_q <= ST_LAST;
          end else if (c_q == lim_q) begin
            c_q <= '0;
            r_q <= r_q + 2'd1;
          end else begin
            c_q <= c_q + 2'd1;
          end
        end
        ST_LAST: st_q <= ST_FIRE;
        ST_FIRE: st_q <= ST_WAIT;
        ST_WAIT: if (core_done_i) begin
          if (kk_q == nbm1_q) begin
            st_q <= ST_WRITE;
          end else begin
            kk_q <= kk_q + 1'b1;
            st_q <= ST_LOAD;
          end
        end
        ST_WRITE: begin
          if (pos_last) begin
            r_q  <= '0;
            c_q  <= '0;
            kk_q <= '0;
            st_q <= ST_LOAD;
            if (bj_q == nbm1_q) begin
              bj_q <= '0;
              if (bi_q == nbm1_q) st_q <= ST_DONE;
              else                bi_q <= bi_q + 1'b1;
            end else begin
              bj_q <= bj_q + 1'b1;
            end
          end else if (c_q == lim_q) begin
            c_q <= '0;
            r_q <= r_q + 2'd1;
          end else begin
            c_q <= c_q + 2'd1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  mm_tile_addr #(.MAX_LG(MAX_LG)) u_addr_a (
    .lg_i(lg_q), .blk_r_i(bi_q), .blk_c_i(kk_q), .r_i(r_q), .c_i(c_q), .addr_o(a_addr_o)
  );
  mm_tile_addr #(.MAX_LG(MAX_LG)) u_addr_b (
    .lg_i(lg_q), .blk_r_i(kk_q), .blk_c_i(bj_q), .r_i(r_q), .c_i(c_q), .addr_o(b_addr_o)
  );
  mm_tile_addr #(.MAX_LG(MAX_LG)) u_addr_c (
    .lg_i(lg_q), .blk_r_i(bi_q), .blk_c_i(bj_q), .r_i(r_q), .c_i(c_q), .addr_o(wr_addr_o)
  );

  mm_tile_opnd #(.DW(DW)) u_opnd (
    .clk_i, .rst_ni,
    .clr_i (opnd_clr),
    .we_i  (cap_v_q),
    .idx_i (cap_idx_q),
    .a_i   (a_data_i),
    .b_i   (b_data_i),
    .a_o   (core_a_o),
    .b_o   (core_b_o)
  );

  mm_tile_psum #(.OW(OW)) u_psum (
    .clk_i, .rst_ni,
    .en_i     (accum),
    .clr_i    (kk_q == '0),
    .c_i      (core_c_i),
    .rd_idx_i ({r_q, c_q}),
    .rd_o     (wr_data_o)
  );

  assign a_rd_o       = (st_q == ST_LOAD);
  assign b_rd_o       = (st_q == ST_LOAD);
  assign core_start_o = (st_q == ST_FIRE);
  assign wr_en_o      = (st_q == ST_WRITE);
  assign done_o       = (st_q == ST_DONE);
endmodule

// File: rtl/mm_tile_chk.sv
module mm_tile_chk
  import mm_tile_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MAX_LG = 4,
  localparam int AW = 2 * MAX_LG
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   done_o,
  input logic                   wr_en_o,
  input logic [AW-1:0]          wr_addr_o,
  input logic                   core_start_o,
  input logic                   core_done_i,
  input logic [TILE_ENT*DW-1:0] core_a_o,
  input logic [TILE_ENT*DW-1:0] core_b_o,
  input logic [2:0]             lg_q
);
  logic in_flight_q;
  logic pad_nz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           in_flight_q <= 1'b0;
    else if (core_start_o) in_flight_q <= 1'b1;
    else if (core_done_i)  in_flight_q <= 1'b0;
  end

  always_comb begin
    pad_nz = 1'b0;
    for (int e = 0; e < TILE_ENT; e++) begin
      if ((e / 4) >= 2 || (e % 4) >= 2)
        pad_nz = pad_nz | (|core_a_o[e*DW +: DW]) | (|core_b_o[e*DW +: DW]);
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_en_o));
  // R3
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  // R10
  one_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> !in_flight_q);
  // R6
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((wr_addr_o >> {lg_q, 1'b0}) == '0));
  // R5
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_start_o && lg_q == 3'd1) |-> !pad_nz);
endmodule

bind mm_tile_ctrl mm_tile_chk #(.DW(DW), .MAX_LG(MAX_LG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_o       (done_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .core_start_o (core_start_o),
  .core_done_i  (core_done_i),
  .core_a_o     (core_a_o),
  .core_b_o     (core_b_o),
  .lg_q         (lg_q)
);

// File: tb/mm_tile_ctrl_test.sv
module mm_tile_ctrl_test;
  localparam int DW = 32;
  localparam int OW = 64;
  localparam int NE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            start = 1'b0;
  logic [1:0]      size = '0;
  logic            done, a_rd, b_rd, wr_en, core_start;
  logic [7:0]      a_addr, b_addr, wr_addr;
  logic [DW-1:0]   a_data, b_data;
  logic [OW-1:0]   wr_data;
  logic [NE*DW-1:0] core_a, core_b;
  logic            core_done = 1'b0;
  logic [NE*OW-1:0] core_c = '0;

  mm_tile_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .done_o(done),
    .a_rd_o(a_rd), .a_addr_o(a_addr), .a_data_i(a_data),
    .b_rd_o(b_rd), .b_addr_o(b_addr), .b_data_i(b_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .core_start_o(core_start), .core_a_o(core_a), .core_b_o(core_b),
    .core_done_i(core_done), .core_c_i(core_c)
  );

  logic [DW-1:0] ram_a [256];
  logic [DW-1:0] ram_b [256];
  logic [OW-1:0] ram_c [256];
  int            wr_cnt [256];

  int errs = 0, checks = 0;
  int cur_n = 2;
  int cyc = 0, last_wr_cyc = -10, done_cnt = 0, fire_cnt = 0, last_blk = 0;

  always @(posedge clk) begin
    if (a_rd) a_data <= ram_a[a_addr];
    if (b_rd) b_data <= ram_b[b_addr];
  end

  // behavioural 4x4 core, three cycles of latency
  int core_cd = 0;
  always @(posedge clk) begin
    if (core_start) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          logic [OW-1:0] s;
          s = '0;
          for (int m = 0; m < 4; m++)
            s = s + OW'(core_a[(r*4+m)*DW +: DW]) * OW'(core_b[(m*4+c)*DW +: DW]);
          core_c[(r*4+c)*OW +: OW] <= s;
        end
      core_cd <= 3;
    end else if (core_cd != 0) begin
      core_cd <= core_cd - 1;
    end
    core_done <= (core_cd == 1);
  end

  task automatic check(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] opnd(input bit is_b, input int row, input int col);
    if (row >= cur_n || col >= cur_n) return '0;
    return is_b ? ram_b[row*cur_n+col] : ram_a[row*cur_n+col];
  endfunction

  // monitor: away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && wr_en) begin
      int row, col, blk, nb;
      nb  = (cur_n < 4) ? 1 : cur_n / 4;
      row = int'(wr_addr) / cur_n;
      col = int'(wr_addr) % cur_n;
      blk = (row / 4) * nb + col / 4;
      if (int'(wr_addr) >= cur_n*cur_n)
        check(1'b0, "R6 write outside range", OW'(wr_addr), OW'(cur_n*cur_n));
      else begin
        ram_c[wr_addr] <= wr_data;
        wr_cnt[wr_addr] = wr_cnt[wr_addr] + 1;
      end
      if (blk < last_blk) check(1'b0, "R6 tile order", OW'(blk), OW'(last_blk));
      last_blk    = blk;
      last_wr_cyc = cyc;
    end
    if (rst_n && done) begin
      done_cnt++;
      check(cyc == last_wr_cyc + 1, "R7 done after last write", OW'(cyc), OW'(last_wr_cyc + 1));
    end
    if (rst_n && core_start) begin
      int nb, bi, bj, kk;
      logic [NE*DW-1:0] ea, eb;
      nb = (cur_n < 4) ? 1 : cur_n / 4;
      kk = fire_cnt % nb;
      bj = (fire_cnt / nb) % nb;
      bi = fire_cnt / (nb*nb);
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          ea[(r*4+c)*DW +: DW] = opnd(1'b0, bi*4+r, kk*4+c);
          eb[(r*4+c)*DW +: DW] = opnd(1'b1, kk*4+r, bj*4+c);
        end
      // R3 launch operands, R5 padding for N=2
      check(core_a == ea && core_b == eb, cur_n == 2 ? "R5 padded operands" : "R3 launch operands",
            OW'(fire_cnt), OW'(fire_cnt));
      fire_cnt++;
    end
  end

  task automatic run_case(input logic [1:0] code, input int pat, input bit poke);
    int n, wd;
    n = 2 << code;
    cur_n = n;
    for (int i = 0; i < 256; i++) begin
      case (pat)
        0: begin ram_a[i] = DW'(i % 7 + 1); ram_b[i] = DW'((i * 3) % 11); end
        1: begin ram_a[i] = '1; ram_b[i] = '1; end
        default: begin ram_a[i] = $urandom; ram_b[i] = $urandom; end
      endcase
      ram_c[i] = '0;
      wr_cnt[i] = 0;
    end
    done_cnt = 0; fire_cnt = 0; last_blk = 0; last_wr_cyc = -10;
    @(negedge clk);
    size = code; start = 1'b1;
    @(negedge clk);
    start = 1'b0; size = 2'd0;
    wd = 0;
    while (done_cnt == 0 && wd < 40000) begin
      @(negedge clk);
      wd++;
      if (poke && wd == 30) begin
        size = 2'd3; start = 1'b1;    // R8 start during a run
      end else start = 1'b0;
    end
    if (wd >= 40000) check(1'b0, "R1 watchdog", OW'(wd), 0);
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R7 single done", OW'(done_cnt), 1);
    if (poke) check(fire_cnt == (n/4)*(n/4)*(n/4), "R8 start ignored", OW'(fire_cnt), OW'((n/4)*(n/4)*(n/4)));
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++) begin
        logic [OW-1:0] e;
        e = '0;
        for (int k = 0; k < n; k++) e = e + OW'(ram_a[i*n+k]) * OW'(ram_b[k*n+j]);
        // R1 R2 R4 product value
        check(ram_c[i*n+j] == e, n > 4 ? "R4 accumulated element" : "R1 element", ram_c[i*n+j], e);
        check(wr_cnt[i*n+j] == 1, "R6 written once", OW'(wr_cnt[i*n+j]), 1);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!done && !wr_en && !core_start, "R9 reset outputs", {done, wr_en, core_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(2'd3, 2, 1'b0);
    run_case(2'd2, 1, 1'b0);
    run_case(2'd0, 2, 1'b0);
    run_case(2'd1, 0, 1'b0);
    run_case(2'd2, 0, 1'b1);
    run_case(2'd0, 1, 1'b0);
    run_case(2'd1, 1, 1'b0);
    run_case(2'd3, 1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule